// File: doc/BRIEF.md
# Basic Interval Timer with Cascaded Watchdog

This block keeps time with a free-running basic counter, 8 bits wide by default. A programmable prescaler divides the input clock to make the counter's tick. When the counter wraps from all ones to zero, three things happen:

- a sticky interrupt flag is set;
- the warm-up period that follows reset or an exit from sleep ends;
- a 3-bit watchdog counter advances by one.

If software does not clear the watchdog before it wraps, the block emits a one-cycle request to reset the system.

Software services the watchdog with a clear strobe. The strobe zeroes the prescaler and both counters in one cycle. On the same strobe the watchdog-enable input is captured, so this is also the only moment the watchdog can be switched on or off. The watchdog is enabled out of reset. A sleep-exit request restarts the prescaler and the basic counter and drops the warm-up-done flag. The oscillator stays gated until that flag returns. The watchdog is not touched by a sleep exit.

Top module: `basic_wdog_timer`

## Requirements
- R1: While reset is held and just after it, `irq`, `warm_done` and `rst_req` are low, and the watchdog is already enabled. With no clear strobe, `rst_req` pulses 8 × 2^CNT_W × D clocks after reset release, where D is the selected division.
- R2: `div_sel` picks the tick division D: code 0 → 16, code 1 → 256, code 2 → 1024, code 3 → 4096 input clocks.
- R3: After a clear, the first overflow, and so `irq` rising, comes exactly 2^CNT_W × D clocks later.
- R4: `irq` stays high until `irq_ack` is sampled high, and goes low in the cycle after that. An overflow in the same cycle as the acknowledge keeps `irq` high.
- R5: `warm_done` goes low on reset and on `wake`. It goes high at the first overflow after either, and stays high until the next reset or `wake`.
- R6: `wake` zeroes the prescaler and the basic counter but keeps the watchdog count.
- R7: `clr` zeroes the prescaler, the basic counter and the watchdog. In the same cycle it loads `wdg_en` into the watchdog enable. An overflow coincident with `clr` or `wake` has no effect.
- R8: While enabled, the watchdog advances once per overflow. The 8th overflow since the last clear makes `rst_req` high for exactly one cycle.
- R9: After a watchdog wrap the count continues from zero, so the next pulse follows 8 overflows later.
- R10: When the captured enable is low, the watchdog holds its value and `rst_req` never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Tick division select (code 0..3 → 16, 256, 1024, 4096) |
| clr | input | 1 | Service strobe: zeroes counters and loads the watchdog enable |
| wdg_en | input | 1 | Watchdog enable value captured on `clr` |
| wake | input | 1 | Sleep-exit request: restarts the warm-up count |
| irq_ack | input | 1 | Acknowledge for the sticky interrupt flag |
| irq | output | 1 | Sticky basic-timer interrupt flag |
| warm_done | output | 1 | High once the warm-up period has elapsed |
| rst_req | output | 1 | One-cycle system reset request from the watchdog |

## Verification
The embedded properties assume two things about the inputs:

- `clr`, `wake` and `irq_ack` are synchronous to `clk`;
- `div_sel` may change at any time, because a changed division only shifts the next tick and never produces two ticks in a row.

The stimulus changes `div_sel` only before a clear, so every interval the bench predicts starts from a zero prescaler. It also keeps acknowledges and clears away from overflow instants, except where that coincidence is itself the case under test.

The bench runs two copies of the block:

- the default 8-bit counter, for the absolute timings;
- a 4-bit variant, so that all four divisions and repeated watchdog wraps fit within the run.

Each expected cycle is derived arithmetically from the clear, reset-release or wake edge.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

    // Number of selectable tick divisions
    localparam int NUM_DIV = 4;

    typedef enum logic [1:0] {
        DIV_A = 2'd0,
        DIV_B = 2'd1,
        DIV_C = 2'd2,
        DIV_D = 2'd3
    } div_code_e;

endpackage

// File: rtl/bwt_prescale.sv
module bwt_prescale #(
    parameter int SH0   = 4,
    parameter int SH1   = 8,
    parameter int SH2   = 10,
    parameter int SH3   = 12,
    parameter int PRE_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] div_sel,
    output logic       tick
);
    import bwt_pkg::*;

    localparam int SH_TAB [NUM_DIV] = '{SH0, SH1, SH2, SH3};

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PRE_W-1:0] mask [NUM_DIV];

    genvar g;
    generate
        for (g = 0; g < NUM_DIV; g++) begin : g_mask
            assign mask[g] = PRE_W'((64'd1 << SH_TAB[g]) - 64'd1);
        end
    endgenerate

    assign tick = ((st_q.pre & mask[div_sel]) == mask[div_sel]);

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/bwt_basic.sv
module bwt_basic #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    input  logic wake,
    input  logic irq_ack,
    output logic ovf,
    output logic irq,
    output logic warm_done
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             warm;
    } basic_state_t;

    basic_state_t st_d, st_q;

    assign ovf       = tick && (&st_q.cnt) && !clr && !wake;
    assign irq       = st_q.irq;
    assign warm_done = st_q.warm;

    always_comb begin
        st_d = st_q;
        if (clr || wake) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (ovf) begin
            st_d.irq = 1'b1;
        end else if (irq_ack) begin
            st_d.irq = 1'b0;
        end
        if (wake) begin
            st_d.warm = 1'b0;
        end else if (ovf) begin
            st_d.warm = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !irq_ack) |=> st_q.irq);

    // R5
    warm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.warm) |-> $past(ovf));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0));

endmodule

// File: rtl/bwt_wdog.sv
module bwt_wdog #(
    parameter int WDG_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic clr,
    input  logic wdg_en,
    output logic rst_req
);
    typedef struct packed {
        logic [WDG_W-1:0] wd;
        logic             en;
        logic             req;
    } wdog_state_t;

    wdog_state_t st_d, st_q;

    assign rst_req = st_q.req;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (clr) begin
            st_d.wd = '0;
            st_d.en = wdg_en;
        end else if (ovf && st_q.en) begin
            st_d.wd  = st_q.wd + 1'b1;
            st_d.req = &st_q.wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |=> !st_q.req);

    // R8
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |-> $past(ovf && st_q.en));

    // R10
    wd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !clr) |=> $stable(st_q.wd));

endmodule

// File: rtl/basic_wdog_timer.sv
module basic_wdog_timer #(
    parameter int SH0   = 4,
    parameter int SH1   = 8,
    parameter int SH2   = 10,
    parameter int SH3   = 12,
    parameter int CNT_W = 8,
    parameter int WDG_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_sel,
    input  logic       clr,
    input  logic       wdg_en,
    input  logic       wake,
    input  logic       irq_ack,
    output logic       irq,
    output logic       warm_done,
    output logic       rst_req
);
    localparam int PRE_W = SH3;

    logic tick;
    logic ovf;
    logic restart;

    assign restart = clr || wake;

    bwt_prescale #(
        .SH0   (SH0),
        .SH1   (SH1),
        .SH2   (SH2),
        .SH3   (SH3),
        .PRE_W (PRE_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .div_sel (div_sel),
        .tick    (tick)
    );

    bwt_basic #(
        .CNT_W (CNT_W)
    ) u_basic (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .clr       (clr),
        .wake      (wake),
        .irq_ack   (irq_ack),
        .ovf       (ovf),
        .irq       (irq),
        .warm_done (warm_done)
    );

    bwt_wdog #(
        .WDG_W (WDG_W)
    ) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf     (ovf),
        .clr     (clr),
        .wdg_en  (wdg_en),
        .rst_req (rst_req)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq && !warm_done && !rst_req));

endmodule

// File: tb/basic_wdog_timer_tb.sv
module basic_wdog_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic       clr = 1'b0;
    logic       wdg_en = 1'b1;
    logic       wake = 1'b0;
    logic       irq_ack = 1'b0;

    logic irq_b, warm_b, rst_b;
    logic irq_s, warm_s, rst_s;

    int checks = 0;
    int failures = 0;
    int ncyc = 0;
    int rs_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    basic_wdog_timer u_dut (
        .clk (clk), .rst_n (rst_n), .div_sel (div_sel), .clr (clr),
        .wdg_en (wdg_en), .wake (wake), .irq_ack (irq_ack),
        .irq (irq_b), .warm_done (warm_b), .rst_req (rst_b)
    );

    basic_wdog_timer #(.CNT_W (4)) u_dut_s (
        .clk (clk), .rst_n (rst_n), .div_sel (div_sel), .clr (clr),
        .wdg_en (wdg_en), .wake (wake), .irq_ack (irq_ack),
        .irq (irq_s), .warm_done (warm_s), .rst_req (rst_s)
    );

    always @(posedge clk) if (rst_s) rs_cnt++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, ncyc, act, exp);
        end
    endtask

    task automatic wait_to(input int n);
        repeat (n - ncyc) @(negedge clk);
        ncyc = n;
    endtask

    task automatic do_clr(input logic en);
        @(negedge clk);
        clr = 1'b1; wdg_en = en; irq_ack = 1'b1;
        @(negedge clk);
        clr = 1'b0; irq_ack = 1'b0;
        ncyc = 0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1;
        wait_to(ncyc + 1);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL all-requirements timeout: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int snap;
        // R1: outputs quiet in reset
        repeat (3) @(negedge clk);
        check("R1 irq in reset", int'(irq_b), 0);
        check("R1 warm in reset", int'(warm_b), 0);
        check("R1 rst_req in reset", int'(rst_b), 0);
        rst_n = 1'b1;
        ncyc = 0;

        // R1: watchdog enabled at power-up (small copy, P=256)
        wait_to(2047); check("R1 no early rst_req", int'(rst_s), 0);
        wait_to(2048); check("R1 power-up watchdog", int'(rst_s), 1);

        // R3 / R5: default copy, P=4096
        wait_to(4095);
        check("R3 irq before overflow", int'(irq_b), 0);
        check("R5 warm before overflow", int'(warm_b), 0);
        wait_to(4096);
        check("R3 irq at overflow", int'(irq_b), 1);
        check("R5 warm at overflow", int'(warm_b), 1);
        wait_to(4196);
        check("R4 irq sticky", int'(irq_b), 1);
        pulse_ack();
        check("R4 irq acked", int'(irq_b), 0);
        wait_to(8191);
        pulse_ack();
        check("R4 overflow beats ack", int'(irq_b), 1);
        check("R5 warm stays", int'(warm_b), 1);

        // R8: default copy wraps its watchdog after 8 overflows
        wait_to(32767); check("R8 rst_req before 8th", int'(rst_b), 0);
        wait_to(32768); check("R8 rst_req on 8th", int'(rst_b), 1);
        wait_to(32769); check("R8 rst_req one cycle", int'(rst_b), 0);

        // R9: repeated wraps on small copy
        do_clr(1'b1);
        wait_to(2047); check("R9 first wrap early", int'(rst_s), 0);
        wait_to(2048); check("R9 first wrap", int'(rst_s), 1);
        wait_to(2049); check("R9 pulse width", int'(rst_s), 0);
        wait_to(4095); check("R9 second wrap early", int'(rst_s), 0);
        wait_to(4096); check("R9 second wrap", int'(rst_s), 1);

        // R6 / R5: wake at edge 778 after 3 small overflows
        do_clr(1'b1);
        wait_to(4096); // both copies now have warm high
        do_clr(1'b1);
        wait_to(777);
        check("R5 warm high before wake", int'(warm_b), 1);
        wake = 1'b1;
        wait_to(778);
        wake = 1'b0;
        check("R5 warm dropped by wake", int'(warm_b), 0);
        check("R5 small warm dropped", int'(warm_s), 0);
        wait_to(2057); check("R6 watchdog kept early", int'(rst_s), 0);
        wait_to(2058); check("R6 watchdog kept count", int'(rst_s), 1);
        wait_to(4873); check("R5 warm low in warm-up", int'(warm_b), 0);
        wait_to(4874); check("R5 warm after wake", int'(warm_b), 1);

        // R10: enable captured low
        do_clr(1'b0);
        snap = rs_cnt;
        wait_to(9 * 256 + 5);
        check("R10 no rst_req when disabled", rs_cnt - snap, 0);
        check("R10 basic counter still runs", int'(irq_s), 1);

        // R7: re-enable and clear mid-count restarts the watchdog
        do_clr(1'b1);
        wait_to(5 * 256 + 3);
        do_clr(1'b1);
        snap = rs_cnt;
        wait_to(2047);
        check("R7 old deadline ignored", rs_cnt - snap, 0);
        wait_to(2048);
        check("R7 new deadline", int'(rst_s), 1);

        // R2 / R3: division sweep on small copy, P = 16 * D
        for (int sel = 0; sel < 4; sel++) begin
            int per;
            per = 16 * (sel == 0 ? 16 : sel == 1 ? 256 : sel == 2 ? 1024 : 4096);
            div_sel = sel[1:0];
            do_clr(1'b1);
            wait_to(per - 1);
            check($sformatf("R2 sel=%0d irq early", sel), int'(irq_s), 0);
            wait_to(per);
            check($sformatf("R2 sel=%0d irq period", sel), int'(irq_s), 1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule